// File: doc/BRIEF.md
# Store Queue with Commit Tracking

This block holds every in-flight store of an out-of-order core in a circular buffer. A store receives an entry at dispatch, in program order, and the entry is tagged with the store's sequence number. The execute stage fills in the entry's address, byte size and data later, by entry index. A commit request carrying a sequence number marks every older store as committed and allowed to write back. The oldest entry is offered on a single memory write port, and it leaves the queue only after the memory side acknowledges the write.

A squash request removes every store younger than a given sequence number. The free-slot pointer is then pulled back to sit just past the youngest store that survives. The contents of all entries are exported in flattened form, with a valid bit per entry and the index of the oldest entry, so that a separate forwarding unit can search them. An entry whose size is still zero has not executed, and that unit must skip it. The queue reports full one slot before it is completely occupied. An allocation that arrives while the queue is full is refused and leaves a sticky error bit set.

Top module: `store_queue`

## Requirements
- R1: An allocation is accepted when the queue is not full and no squash is requested in the same cycle. The new entry takes the slot shown on `alloc_idx`, records `alloc_seq`, has size zero and all status flags clear, and the slot pointer advances by one, wrapping from DEPTH-1 to 0.
- R2: `full` is high whenever the occupied count is DEPTH-1 or more. An allocation request while `full` is refused, and it sets `overflow_err`, which stays high until reset.
- R3: An execute request writes address, size and data into the occupied entry named by `exec_idx`. It produces no activity on the memory write port.
- R4: A freshly allocated entry exports size zero, which marks it as not yet executed.
- R5: A commit request marks every occupied entry whose sequence number, compared as an unsigned value, is below `commit_seq` as committed and allowed to write back. Entries with an equal or greater number stay uncommitted.
- R6: `wb_valid` is high only when the oldest entry is allowed to write back and is not yet completed. `wb_addr`, `wb_size` and `wb_data` then show that entry's fields, so writes leave strictly in allocation order.
- R7: When `wb_ack` is high together with `wb_valid`, the entry is marked completed and `wb_valid` is low in the next cycle. The entry is freed at the clock edge after that, and the occupied count drops by one.
- R8: A squash request removes every entry whose sequence number is greater than `squash_seq`. Any allocation in that cycle is refused. The next accepted allocation takes the slot just after the youngest surviving entry.
- R9: When a completed entry retires in the same cycle as an accepted allocation, the occupied count is unchanged.
- R10: After reset the queue is empty: the count is zero, no entry is valid, `wb_valid` is low and `overflow_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_accept | output | 1 | Allocation taken this cycle |
| alloc_idx | output | IW | Slot the allocation uses |
| exec_valid | input | 1 | Execute write request |
| exec_idx | input | IW | Target entry of the execute write |
| exec_addr | input | ADDR_W | Store address |
| exec_size | input | SIZE_W | Store size in bytes, non-zero |
| exec_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Stores older than this number commit |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Stores younger than this number are removed |
| wb_valid | output | 1 | Oldest entry offered for writing to memory |
| wb_addr | output | ADDR_W | Address of offered write |
| wb_size | output | SIZE_W | Size of offered write |
| wb_data | output | DATA_W | Data of offered write |
| wb_ack | input | 1 | Memory accepted the offered write |
| full | output | 1 | Occupied count at DEPTH-1 or more |
| empty | output | 1 | No occupied entry |
| count | output | CW | Occupied entry count |
| overflow_err | output | 1 | Sticky: allocation was attempted while full |
| head_idx | output | IW | Index of the oldest entry |
| ent_valid | output | DEPTH | Per-entry occupied bit |
| ent_committed | output | DEPTH | Per-entry committed bit |
| ent_seq | output | DEPTH*SEQ_W | Flattened sequence numbers |
| ent_addr | output | DEPTH*ADDR_W | Flattened addresses |
| ent_size | output | DEPTH*SIZE_W | Flattened sizes, zero when not executed |
| ent_data | output | DEPTH*DATA_W | Flattened data |

## Verification
Two functions can act in the same clock edge: retirement of the completed oldest entry and allocation of a new one. Each of them changes the count and a pointer. The bench acknowledges a write and then requests an allocation exactly one cycle later, so that the allocation lands on the edge where the retirement happens. It then judges that the count is unchanged, that the new slot follows the old tail without disturbing the head, and that the next entry's offer appears in order. A second overlap is also provoked: a squash and an allocation arrive together, and the bench confirms the allocation is refused and the slot pointer is pulled back.

// File: rtl/store_queue.sv
module store_queue #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 8,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4,
  parameter int DATA_W = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_valid,
  input  logic [SEQ_W-1:0]        alloc_seq,
  output logic                    alloc_accept,
  output logic [IW-1:0]           alloc_idx,
  input  logic                    exec_valid,
  input  logic [IW-1:0]           exec_idx,
  input  logic [ADDR_W-1:0]       exec_addr,
  input  logic [SIZE_W-1:0]       exec_size,
  input  logic [DATA_W-1:0]       exec_data,
  input  logic                    commit_valid,
  input  logic [SEQ_W-1:0]        commit_seq,
  input  logic                    squash_valid,
  input  logic [SEQ_W-1:0]        squash_seq,
  output logic                    wb_valid,
  output logic [ADDR_W-1:0]       wb_addr,
  output logic [SIZE_W-1:0]       wb_size,
  output logic [DATA_W-1:0]       wb_data,
  input  logic                    wb_ack,
  output logic                    full,
  output logic                    empty,
  output logic [CW-1:0]           count,
  output logic                    overflow_err,
  output logic [IW-1:0]           head_idx,
  output logic [DEPTH-1:0]        ent_valid,
  output logic [DEPTH-1:0]        ent_committed,
  output logic [DEPTH*SEQ_W-1:0]  ent_seq,
  output logic [DEPTH*ADDR_W-1:0] ent_addr,
  output logic [DEPTH*SIZE_W-1:0] ent_size,
  output logic [DEPTH*DATA_W-1:0] ent_data
);

  logic [DEPTH-1:0]  occ_q, canwb_q, cmt_q, done_q, keep;
  logic [SEQ_W-1:0]  seq_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [SIZE_W-1:0] size_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [IW-1:0]     head_q, tail_q, head_nx, tail_nx, tail_sq;
  logic [CW-1:0]     cnt_q, survivors;
  logic [IW:0]       tail_sum;
  logic              retire, ovf_q;

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full         = cnt_q >= CW'(DEPTH - 1);
  assign empty        = cnt_q == '0;
  assign count        = cnt_q;
  assign overflow_err = ovf_q;
  assign head_idx     = head_q;
  assign alloc_idx    = tail_q;
  assign alloc_accept = alloc_valid && !full && !squash_valid;
  assign retire       = occ_q[head_q] && done_q[head_q];

  assign wb_valid = occ_q[head_q] && canwb_q[head_q] && !done_q[head_q];
  assign wb_addr  = addr_q[head_q];
  assign wb_size  = size_q[head_q];
  assign wb_data  = data_q[head_q];

  always_comb begin
    survivors = '0;
    for (int i = 0; i < DEPTH; i++) begin
      keep[i] = occ_q[i] && !(squash_valid && (seq_q[i] > squash_seq));
      survivors = survivors + CW'(keep[i]);
    end
    tail_sum = {1'b0, head_q} + (IW + 1)'(survivors);
    tail_sq  = (tail_sum >= (IW + 1)'(DEPTH)) ? IW'(tail_sum - (IW + 1)'(DEPTH)) : tail_sum[IW-1:0];
    head_nx  = retire ? bump(head_q) : head_q;
    tail_nx  = squash_valid ? tail_sq : (alloc_accept ? bump(tail_q) : tail_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q   <= '0;
      canwb_q <= '0;
      cmt_q   <= '0;
      done_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        seq_q[i]  <= '0;
        addr_q[i] <= '0;
        size_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!keep[i]) occ_q[i] <= 1'b0;
        if (commit_valid && occ_q[i] && (seq_q[i] < commit_seq)) begin
          canwb_q[i] <= 1'b1;
          cmt_q[i]   <= 1'b1;
        end
        if (exec_valid && (exec_idx == IW'(i)) && keep[i]) begin
          addr_q[i] <= exec_addr;
          size_q[i] <= exec_size;
          data_q[i] <= exec_data;
        end
        if (wb_valid && wb_ack && (head_q == IW'(i))) done_q[i] <= 1'b1;
      end
      if (retire) occ_q[head_q] <= 1'b0;
      if (alloc_accept) begin
        occ_q[tail_q]   <= 1'b1;
        canwb_q[tail_q] <= 1'b0;
        cmt_q[tail_q]   <= 1'b0;
        done_q[tail_q]  <= 1'b0;
        seq_q[tail_q]   <= alloc_seq;
        size_q[tail_q]  <= '0;
      end
      head_q <= head_nx;
      tail_q <= tail_nx;
      if (squash_valid)
        cnt_q <= survivors - CW'(retire);
      else
        cnt_q <= cnt_q + CW'(alloc_accept) - CW'(retire);
      if (alloc_valid && full) ovf_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_export
    assign ent_valid[g]                      = occ_q[g];
    assign ent_committed[g]                  = cmt_q[g];
    assign ent_seq [g*SEQ_W  +: SEQ_W]       = seq_q[g];
    assign ent_addr[g*ADDR_W +: ADDR_W]      = addr_q[g];
    assign ent_size[g*SIZE_W +: SIZE_W]      = size_q[g];
    assign ent_data[g*DATA_W +: DATA_W]      = data_q[g];
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH - 1));

  assert_overflow_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && full |=> ovf_q);

  assert_overflow_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  assert_offer_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ack |=> !wb_valid);

  assert_offer_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ack && !squash_valid |=> wb_valid && $stable(head_q));

  assert_empty_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !wb_valid);

  assert_squash_no_alloc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> $stable(tail_q) || (cnt_q <= $past(cnt_q)));

endmodule

// File: tb/store_queue_tb_top.sv
module store_queue_tb_top;
  localparam int DEPTH = 4, SEQ_W = 8, ADDR_W = 16, SIZE_W = 4, DATA_W = 32;
  localparam int IW = $clog2(DEPTH), CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, exec_valid = 0, commit_valid = 0, squash_valid = 0, wb_ack = 0;
  logic [SEQ_W-1:0] alloc_seq = 0, commit_seq = 0, squash_seq = 0;
  logic [IW-1:0] exec_idx = 0;
  logic [ADDR_W-1:0] exec_addr = 0;
  logic [SIZE_W-1:0] exec_size = 0;
  logic [DATA_W-1:0] exec_data = 0;
  logic alloc_accept, wb_valid, full, empty, overflow_err;
  logic [IW-1:0] alloc_idx, head_idx;
  logic [ADDR_W-1:0] wb_addr;
  logic [SIZE_W-1:0] wb_size;
  logic [DATA_W-1:0] wb_data;
  logic [CW-1:0] count;
  logic [DEPTH-1:0] ent_valid, ent_committed;
  logic [DEPTH*SEQ_W-1:0] ent_seq;
  logic [DEPTH*ADDR_W-1:0] ent_addr;
  logic [DEPTH*SIZE_W-1:0] ent_size;
  logic [DEPTH*DATA_W-1:0] ent_data;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  store_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) dut_i (
    .clk, .rst_n, .alloc_valid, .alloc_seq, .alloc_accept, .alloc_idx,
    .exec_valid, .exec_idx, .exec_addr, .exec_size, .exec_data,
    .commit_valid, .commit_seq, .squash_valid, .squash_seq,
    .wb_valid, .wb_addr, .wb_size, .wb_data, .wb_ack,
    .full, .empty, .count, .overflow_err, .head_idx,
    .ent_valid, .ent_committed, .ent_seq, .ent_addr, .ent_size, .ent_data);

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic alloc(input logic [7:0] s, input logic exp_acc, input int exp_idx, input string req);
    alloc_valid = 1; alloc_seq = s; #1;
    check(req, "alloc_accept", alloc_accept, exp_acc);
    if (exp_acc) check(req, "alloc_idx", alloc_idx, exp_idx);
    tick(); alloc_valid = 0;
  endtask

  task automatic exec(input int idx, input logic [15:0] a, input logic [3:0] sz, input logic [31:0] d);
    exec_valid = 1; exec_idx = IW'(idx); exec_addr = a; exec_size = sz; exec_data = d;
    tick(); exec_valid = 0;
  endtask

  task automatic t_reset();
    check("R10", "empty", empty, 1);
    check("R10", "count", count, 0);
    check("R10", "ent_valid", ent_valid, 0);
    check("R10", "wb_valid", wb_valid, 0);
    check("R10", "overflow_err", overflow_err, 0);
  endtask

  task automatic t_fill();
    alloc(8'd10, 1, 0, "R1");
    alloc(8'd11, 1, 1, "R1");
    check("R4", "size of fresh entry", ent_size[1*SIZE_W +: SIZE_W], 0);
    alloc(8'd12, 1, 2, "R1");
    check("R2", "full at DEPTH-1", full, 1);
    check("R1", "seq of slot2", ent_seq[2*SEQ_W +: SEQ_W], 12);
    alloc(8'd13, 0, 0, "R2");
    check("R2", "overflow set", overflow_err, 1);
    check("R2", "count after refuse", count, 3);
  endtask

  task automatic t_exec();
    exec(0, 16'h0040, 4'd4, 32'hAAAA0000);
    exec(1, 16'h0100, 4'd2, 32'h0000BBBB);
    check("R3", "addr slot1", ent_addr[1*ADDR_W +: ADDR_W], 16'h0100);
    check("R3", "size slot1", ent_size[1*SIZE_W +: SIZE_W], 2);
    check("R3", "data slot1", ent_data[1*DATA_W +: DATA_W], 32'h0000BBBB);
    check("R3", "no write offer", wb_valid, 0);
  endtask

  task automatic t_commit_wb();
    commit_valid = 1; commit_seq = 8'd12; tick(); commit_valid = 0;
    check("R5", "committed mask", ent_committed, 4'b0011);
    check("R6", "offer oldest", wb_valid, 1);
    check("R6", "offer addr", wb_addr, 16'h0040);
    check("R6", "offer data", wb_data, 32'hAAAA0000);
    wb_ack = 1; tick(); wb_ack = 0;
    check("R7", "offer drops after ack", wb_valid, 0);
    check("R7", "not yet freed", count, 3);
    tick();
    check("R7", "freed next clock", count, 2);
    check("R6", "next offer in order", wb_addr, 16'h0100);
    check("R6", "next offer valid", wb_valid, 1);
    wb_ack = 1; tick(); wb_ack = 0;
    // retire of slot1 coincides with this allocation
    alloc(8'd20, 1, 3, "R9");
    check("R9", "count unchanged", count, 2);
    check("R9", "head moved", head_idx, 2);
    check("R5", "equal seq not committed", wb_valid, 0);
    check("R2", "overflow sticky", overflow_err, 1);
  endtask

  task automatic t_squash();
    alloc(8'd21, 1, 0, "R1");
    check("R1", "wrap count", count, 3);
    squash_valid = 1; squash_seq = 8'd12; alloc_valid = 1; alloc_seq = 8'd99; #1;
    check("R8", "alloc refused in squash", alloc_accept, 0);
    tick(); squash_valid = 0; alloc_valid = 0;
    check("R8", "count after squash", count, 1);
    check("R8", "survivor mask", ent_valid, 4'b0100);
    alloc(8'd30, 1, 3, "R8");
    check("R8", "reused slot seq", ent_seq[3*SEQ_W +: SEQ_W], 30);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_fill();
    t_exec();
    t_commit_wb();
    t_squash();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule